// File: doc/BRIEF.md
# Masked Sticky Stream Error Flag

This block gathers single-cycle error strobes from a received video data path and folds them into one active-low error flag in the pixel clock domain. Each strobe lane has an enable bit in a host-writable mask. An enabled strobe sets its own bit in a sticky status register. The flag is low whenever any status bit is set, and high when the stream has arrived clean.

The status bits clear in two ways: a frame or field start pulse, or a host read of the status register. A read returns the bits as they stood before the clear. The clear takes effect on the following clock edge. A strobe that arrives in the same cycle as a clear is kept, so no error is lost at a frame boundary or at a read. This block does not detect the errors. It only records them, masks them and reports them.

The host port is a plain register port with read and write strobes. Read data is combinational. Address 0 holds the status register, which is read-only and cleared by a read. Address 1 holds the mask. Every other address reads as zero.

Top module: `err_flag_top`

## Requirements
- R1: After reset, all status bits are 0, the mask reads 8'hFF (every source enabled), and `err_n_o` is 1.
- R2: A strobe on `err_i[k]` while mask bit k is 1 sets status bit k at that clock edge, and `err_n_o` reads 0 after that edge.
- R3: A strobe on `err_i[k]` while mask bit k is 0 leaves status bit k at 0 and has no effect on `err_n_o`.
- R4: A set status bit stays set while no clear event occurs, even after its strobe has gone away.
- R5: A cycle with `frame_start_i` high clears every status bit at that edge, except bits struck by an enabled strobe in that same cycle.
- R6: With `host_rd_i` high and `host_addr_i` = 0, `host_rdata_o` shows the status bits as they were before the clear in that same cycle, and the bits clear at the following edge.
- R7: When a clear event (frame start or status read) and an enabled strobe occur in the same cycle, the struck bits stay set after the edge, so `err_n_o` stays 0.
- R8: A write with `host_addr_i` = 1 loads the mask from `host_wdata_i` at that edge, and reading address 1 returns the mask.
- R9: A write to address 0 has no effect on the status bits. A read of address 1 does not clear the status bits.
- R10: `err_n_o` is 0 exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | N_ERR | Per-source error strobes, active high |
| frame_start_i | input | 1 | Pulse at the start of a frame or field |
| host_addr_i | input | ADDR_W | Host register address |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe (clears status at address 0) |
| host_wdata_i | input | N_ERR | Host write data |
| host_rdata_o | output | N_ERR | Host read data, combinational |
| err_n_o | output | 1 | Error flag, low while any status bit is set |

## Verification
The bench targets the cycles where a clear and a new error meet. A design that gives the clear priority would drop the new error at a frame start or at a status read, and the flag would wrongly return high. It also checks that a status read returns the bits from before the clear. A design that clears before the data is sampled would hand the host zero. Finally, it checks that masked strobes, writes to the status address and reads of the mask address leave the status bits alone. A design that decodes addresses loosely would clear or set status bits in those cases.

// File: rtl/err_flag_pkg.sv
package err_flag_pkg;
  parameter int unsigned STATUS_ADDR = 0;
  parameter int unsigned MASK_ADDR   = 1;
endpackage

// File: rtl/err_mask_reg.sv
module err_mask_reg #(
  parameter int unsigned N_ERR = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [N_ERR-1:0] wdata_i,
  output logic [N_ERR-1:0] mask_o
);
  // every source monitored out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end

  a_r8_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o == $past(wdata_i));
  a_r8_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int unsigned N_ERR = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ERR-1:0] err_i,
  input  logic [N_ERR-1:0] mask_i,
  input  logic             clear_i,
  output logic [N_ERR-1:0] sticky_o
);
  logic [N_ERR-1:0] hit;
  assign hit = err_i & mask_i;

  for (genvar i = 0; i < N_ERR; i++) begin : g_bit
    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sticky_o[i] <= 1'b0;
      else         sticky_o[i] <= (sticky_o[i] & ~clear_i) | hit[i];
    end
  end

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i & mask_i) != '0 |=>
      (sticky_o & $past(err_i & mask_i)) == $past(err_i & mask_i));
  a_r4_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (sticky_o & $past(sticky_o)) == $past(sticky_o));
  a_r5_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && err_i == '0) |=> sticky_o == '0);
  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i & ~mask_i & ~sticky_o) != '0 |=>
      (sticky_o & $past(err_i & ~mask_i & ~sticky_o)) == '0);
endmodule

// File: rtl/err_host_if.sv
module err_host_if
  import err_flag_pkg::*;
#(
  parameter int unsigned N_ERR  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [N_ERR-1:0]  status_i,
  input  logic [N_ERR-1:0]  mask_i,
  output logic              mask_we_o,
  output logic              rd_clear_o,
  output logic [N_ERR-1:0]  rdata_o
);
  logic sel_status, sel_mask;
  assign sel_status = (addr_i == ADDR_W'(STATUS_ADDR));
  assign sel_mask   = (addr_i == ADDR_W'(MASK_ADDR));

  assign mask_we_o  = wr_i & sel_mask;
  assign rd_clear_o = rd_i & sel_status;

  always_comb begin
    rdata_o = '0;
    if (sel_status)    rdata_o = status_i;
    else if (sel_mask) rdata_o = mask_i;
  end
endmodule

// File: rtl/err_flag_top.sv
module err_flag_top #(
  parameter int unsigned N_ERR  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ERR-1:0]  err_i,
  input  logic              frame_start_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [N_ERR-1:0]  host_wdata_i,
  output logic [N_ERR-1:0]  host_rdata_o,
  output logic              err_n_o
);
  logic [N_ERR-1:0] mask, status;
  logic             mask_we, rd_clear, clear;

  err_host_if #(.N_ERR(N_ERR), .ADDR_W(ADDR_W)) u_host (
    .addr_i    (host_addr_i),
    .wr_i      (host_wr_i),
    .rd_i      (host_rd_i),
    .status_i  (status),
    .mask_i    (mask),
    .mask_we_o (mask_we),
    .rd_clear_o(rd_clear),
    .rdata_o   (host_rdata_o)
  );

  err_mask_reg #(.N_ERR(N_ERR)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(host_wdata_i),
    .mask_o (mask)
  );

  assign clear = frame_start_i | rd_clear;

  err_sticky_bank #(.N_ERR(N_ERR)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_i),
    .mask_i  (mask),
    .clear_i (clear),
    .sticky_o(status)
  );

  assign err_n_o = ~|status;

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && host_addr_i == '0 && err_i == '0) |=> err_n_o);
  a_r9_wr_status_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == '0 && !host_rd_i && !frame_start_i) |=>
      (status & $past(status)) == $past(status));
endmodule

// File: tb/sim_err_flag_top.sv
module sim_err_flag_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] err = '0;
  logic       fs = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       err_n;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  err_flag_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .frame_start_i(fs),
    .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .err_n_o(err_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // peek status without clearing
  task automatic peek(input string req, input logic [7:0] exp_st, input logic exp_n);
    addr = 2'd0; rd = 1'b0;
    #1;
    chk(req, rdata, exp_st);
    chk(req, {7'd0, err_n}, {7'd0, exp_n});
  endtask

  task automatic pulse_err(input logic [7:0] v);
    err = v; step(); err = '0;
  endtask

  task automatic frame_clear();
    fs = 1'b1; step(); fs = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] v);
    addr = 2'd1; wr = 1'b1; wdata = v; step(); wr = 1'b0;
  endtask

  task automatic t_reset();
    peek("R1 status/flag", 8'h00, 1'b1);
    addr = 2'd1; #1;
    chk("R1 mask default", rdata, 8'hFF);
    addr = 2'd3; #1;
    chk("R1 unused addr", rdata, 8'h00);
  endtask

  task automatic t_set_sticky();
    pulse_err(8'h04);
    peek("R2 set bit", 8'h04, 1'b0);
    step(); step();
    peek("R4 sticky", 8'h04, 1'b0);
    pulse_err(8'h81);
    peek("R4 accumulate", 8'h85, 1'b0);
    frame_clear();
    peek("R5 frame clear", 8'h00, 1'b1);
  endtask

  task automatic t_mask();
    write_mask(8'h0F);
    addr = 2'd1; #1;
    chk("R8 mask readback", rdata, 8'h0F);
    pulse_err(8'hF0);
    peek("R3 masked ignored", 8'h00, 1'b1);
    pulse_err(8'h11);
    peek("R3 partial mask", 8'h01, 1'b0);
    frame_clear();
    write_mask(8'hFF);
    peek("R8 restore", 8'h00, 1'b1);
  endtask

  task automatic t_read_clear();
    pulse_err(8'h42);
    addr = 2'd0; rd = 1'b1; #1;
    chk("R6 read pre-clear value", rdata, 8'h42);
    step(); rd = 1'b0;
    peek("R6 cleared after read", 8'h00, 1'b1);
    peek("R10 flag high when clean", 8'h00, 1'b1);
  endtask

  task automatic t_collide();
    pulse_err(8'h02);
    fs = 1'b1; err = 8'h08; step(); fs = 1'b0; err = '0;
    peek("R7 frame vs new error", 8'h08, 1'b0);
    addr = 2'd0; rd = 1'b1; err = 8'h01; #1;
    chk("R7 read value", rdata, 8'h08);
    step(); rd = 1'b0; err = '0;
    peek("R7 read vs new error", 8'h01, 1'b0);
    frame_clear();
    peek("R5 clear after collide", 8'h00, 1'b1);
  endtask

  task automatic t_ignore();
    pulse_err(8'h10);
    addr = 2'd0; wr = 1'b1; wdata = 8'h00; step(); wr = 1'b0;
    peek("R9 status write ignored", 8'h10, 1'b0);
    addr = 2'd1; rd = 1'b1; step(); rd = 1'b0;
    peek("R9 mask read no clear", 8'h10, 1'b0);
    addr = 2'd1; #1;
    chk("R9 mask unchanged", rdata, 8'hFF);
    frame_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_sticky();
    t_mask();
    t_read_clear();
    t_collide();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule